// File: doc/BRIEF.md
# Six-Source Prioritised Interrupt Controller

This block collects interrupt requests from six sources and decides which one a processor core should service next. Four of the sources arrive on active-low pins. Each pin passes through a resynchronising chain, and a falling edge on it sets that source's pending bit. Internal sources, such as timers and a serial port, set pending bits with one-cycle pulses. A mask register holds one enable per source plus a global enable. A priority register chooses one of six orderings of three source pairs, and holds one swap bit per pair.

The core raises `sample_stb` once per instruction, just before its opcode fetch. When that strobe sees an enabled pending source, the block grants it. The grant does four things on the same clock edge:
- it pulses `irq_take`;
- it presents the winning index on `irq_vec`;
- it clears the serviced pending bit;
- it drops the global enable.

A return-from-interrupt or an enable-interrupts operation sets the global enable again. For polled handling, software reads `req_state` and clears bits through `req_clr`. Pushing state and fetching the vector are left to the core.

Top module: `irqc_top`

## Requirements
- R1: After reset, `req_state`, `mask_state` and `irq_take` are all zero.
- R2: Until the first `ei_op` after reset, the pending register stays all zero, whatever arrives on `int_set` or the pins.
- R3: A falling edge on pin i (i < 4) sets pending bit i. The pin is first sampled low on rising edge k, and the bit reads as set after edge k+2, not earlier. A rising edge on a pin sets nothing.
- R4: A one-cycle pulse on `int_set[i]` sets pending bit i. The bit is visible after that same clock edge.
- R5: `mask_wr` stores `mask_wdata` bits 5..0 (the per-source enables) and bit 7 (the global enable). Bit 6 of `mask_state` always reads 0.
- R6: `di_op` clears only bit 7 of `mask_state` and leaves the per-source enables unchanged. `ei_op` and `reti_op` each set bit 7.
- R7: A grant happens only on an edge where `sample_stb` is high, the global enable is 1, and some pending source is enabled. `irq_take` is high for exactly the following cycle, and `irq_vec` then holds the winner's index.
- R8: The priority register's bits 2..0 select the group order, highest first. The groups are A = {5,3}, B = {2,0} and C = {1,4}. Code 1 gives C,A,B; code 2 gives A,B,C; code 3 gives A,C,B; code 4 gives B,C,A; code 5 gives C,B,A; code 6 gives B,A,C. Codes 0 and 7 never produce a grant.
- R9: Priority bits 5, 4 and 3 are the swap bits for groups A, B and C. When a group's swap bit is 0, its first-listed member wins inside the group (5 in A, 2 in B, 1 in C). When the swap bit is 1, the other member wins.
- R10: On a grant, the serviced pending bit is cleared, the other pending bits are kept, and bit 7 of `mask_state` is cleared.
- R11: Every bit set in `req_clr` clears the matching pending bit on the next edge.
- R12: A source whose enable bit is 0 is never granted. The next enabled source in the priority order wins instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 4 | Active-low request pins for sources 0..3 |
| int_set | input | 6 | One-cycle set pulses from internal sources |
| sample_stb | input | 1 | Per-instruction request sampling strobe |
| ei_op | input | 1 | Enable-interrupts: arms the pending register, sets the global enable |
| di_op | input | 1 | Disable-interrupts: clears the global enable |
| reti_op | input | 1 | Return-from-interrupt: sets the global enable |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 8 | Mask write data: bit 7 global enable, bits 5..0 source enables |
| prio_wr | input | 1 | Write strobe for the priority register |
| prio_wdata | input | 6 | Priority data: bits 2..0 order code, bits 5..3 swap bits for A, B, C |
| req_clr | input | 6 | Per-bit clear of pending requests |
| irq_take | output | 1 | Grant pulse |
| irq_vec | output | 3 | Index of the granted source |
| req_state | output | 6 | Pending request register |
| mask_state | output | 8 | Mask register readback |

## Verification
The assertions assume that operations driven by the core do not collide with a grant. A `mask_wr`, `ei_op` or `reti_op` in the same cycle as a granting strobe would lose to the grant's clearing of the global enable. The stimulus therefore never raises any of these in the cycle where `sample_stb` is high.

The assertions also assume that the pins idle high out of reset, and that a `req_clr` never targets a bit being set in the same cycle. The bench follows both rules: it returns pins high before re-arming, and it clears pending bits only while `int_set` is quiet.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // group codes
   localparam logic [1:0] GRP_A = 2'd0;
   localparam logic [1:0] GRP_B = 2'd1;
   localparam logic [1:0] GRP_C = 2'd2;

   localparam int unsigned GRP_COUNT = 3;

   // members of each group: first-listed wins when swap = 0
   localparam int unsigned GRP_FIRST  [GRP_COUNT] = '{5, 2, 1};
   localparam int unsigned GRP_SECOND [GRP_COUNT] = '{3, 0, 4};
   localparam int unsigned GRP_SWAPB  [GRP_COUNT] = '{5, 4, 3};

   typedef struct packed {
      logic       ok;
      logic [1:0] g0;
      logic [1:0] g1;
      logic [1:0] g2;
   } order_t;

   function automatic order_t order_of(input logic [2:0] code);
      order_t o;
      case (code)
         3'd1:    o = '{1'b1, GRP_C, GRP_A, GRP_B};
         3'd2:    o = '{1'b1, GRP_A, GRP_B, GRP_C};
         3'd3:    o = '{1'b1, GRP_A, GRP_C, GRP_B};
         3'd4:    o = '{1'b1, GRP_B, GRP_C, GRP_A};
         3'd5:    o = '{1'b1, GRP_C, GRP_B, GRP_A};
         3'd6:    o = '{1'b1, GRP_B, GRP_A, GRP_C};
         default: o = '{1'b0, GRP_A, GRP_A, GRP_A};
      endcase
      return o;
   endfunction

endpackage

// File: rtl/irqc_fall_sync.sv
module irqc_fall_sync #(
   parameter int unsigned DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall
);

   logic [DEPTH:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[DEPTH-1:0], pin_n};
   end

   assign fall = chain_q[DEPTH] & ~chain_q[DEPTH-1];

   // R3: one falling edge yields a single-cycle event
   p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/irqc_pair_pick.sv
module irqc_pair_pick #(
   parameter int unsigned SRC_N  = 6,
   parameter int unsigned FIRST  = 0,
   parameter int unsigned SECOND = 1,
   localparam int unsigned IDXW  = $clog2(SRC_N)
) (
   input  logic [SRC_N-1:0] pend,
   input  logic             swap,
   output logic             any,
   output logic [IDXW-1:0]  idx
);

   logic p_first, p_second;

   assign p_first  = pend[FIRST];
   assign p_second = pend[SECOND];
   assign any      = p_first | p_second;

   always_comb begin
      if (swap) idx = p_second ? IDXW'(SECOND) : IDXW'(FIRST);
      else      idx = p_first  ? IDXW'(FIRST)  : IDXW'(SECOND);
   end

endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve
   import irqc_pkg::*;
#(
   parameter int unsigned SRC_N = 6,
   localparam int unsigned IDXW = $clog2(SRC_N)
) (
   input  logic [SRC_N-1:0] pend,
   input  logic [5:0]       prio,
   output logic             win_valid,
   output logic [IDXW-1:0]  win_idx
);

   logic [GRP_COUNT-1:0] g_any;
   logic [IDXW-1:0]      g_idx [GRP_COUNT];

   for (genvar g = 0; g < GRP_COUNT; g++) begin : g_pair
      irqc_pair_pick #(
         .SRC_N (SRC_N),
         .FIRST (GRP_FIRST[g]),
         .SECOND(GRP_SECOND[g])
      ) u_pick (
         .pend(pend),
         .swap(prio[GRP_SWAPB[g]]),
         .any (g_any[g]),
         .idx (g_idx[g])
      );
   end

   order_t     ord;
   logic [1:0] seq [GRP_COUNT];

   always_comb begin
      ord       = order_of(prio[2:0]);
      seq[0]    = ord.g0;
      seq[1]    = ord.g1;
      seq[2]    = ord.g2;
      win_valid = 1'b0;
      win_idx   = '0;
      if (ord.ok) begin
         // lowest slot evaluated last so it overrides
         for (int s = GRP_COUNT - 1; s >= 0; s--) begin
            if (g_any[seq[s]]) begin
               win_valid = 1'b1;
               win_idx   = g_idx[seq[s]];
            end
         end
      end
   end

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
   parameter int unsigned SRC_N      = 6,
   parameter int unsigned EXT_LINES  = 4,
   parameter int unsigned SYNC_DEPTH = 2,
   localparam int unsigned IDXW      = $clog2(SRC_N),
   localparam int unsigned MASK_W    = SRC_N + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [EXT_LINES-1:0] ext_irq_n,
   input  logic [SRC_N-1:0]     int_set,
   input  logic                 sample_stb,
   input  logic                 ei_op,
   input  logic                 di_op,
   input  logic                 reti_op,
   input  logic                 mask_wr,
   input  logic [MASK_W-1:0]    mask_wdata,
   input  logic                 prio_wr,
   input  logic [5:0]           prio_wdata,
   input  logic [SRC_N-1:0]     req_clr,
   output logic                 irq_take,
   output logic [IDXW-1:0]      irq_vec,
   output logic [SRC_N-1:0]     req_state,
   output logic [MASK_W-1:0]    mask_state
);

   if (SRC_N != 6) begin : g_bad_src
      $error("irqc_top: the pair priority scheme needs exactly six sources");
   end
   if (EXT_LINES > SRC_N) begin : g_bad_ext
      $error("irqc_top: more pins than sources");
   end
   if (SYNC_DEPTH < 1) begin : g_bad_sync
      $error("irqc_top: synchroniser depth must be at least one");
   end

   logic [SRC_N-1:0] ext_set, set_v, pend_v, grant_oh;
   logic [SRC_N-1:0] req_q, en_q;
   logic [5:0]       prio_q;
   logic             armed_q, gie_q, take_q, grant, win_valid;
   logic [IDXW-1:0]  win_idx, vec_q;

   for (genvar i = 0; i < SRC_N; i++) begin : g_src
      if (i < EXT_LINES) begin : g_pin
         irqc_fall_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin_n(ext_irq_n[i]),
            .fall (ext_set[i])
         );
      end else begin : g_nopin
         assign ext_set[i] = 1'b0;
      end
   end

   assign set_v  = ext_set | int_set;
   assign pend_v = req_q & en_q;

   irqc_resolve #(.SRC_N(SRC_N)) u_res (
      .pend     (pend_v),
      .prio     (prio_q),
      .win_valid(win_valid),
      .win_idx  (win_idx)
   );

   assign grant    = sample_stb & gie_q & win_valid;
   assign grant_oh = grant ? (SRC_N'(1) << win_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         req_q   <= '0;
      end else begin
         if (ei_op) armed_q <= 1'b1;
         if (!armed_q) req_q <= '0;
         else          req_q <= (req_q | set_v) & ~req_clr & ~grant_oh;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q  <= 1'b0;
         en_q   <= '0;
         prio_q <= '0;
      end else begin
         if (mask_wr) en_q   <= mask_wdata[SRC_N-1:0];
         if (prio_wr) prio_q <= prio_wdata;
         if (grant)                gie_q <= 1'b0;
         else if (di_op)           gie_q <= 1'b0;
         else if (ei_op | reti_op) gie_q <= 1'b1;
         else if (mask_wr)         gie_q <= mask_wdata[MASK_W-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         vec_q  <= '0;
      end else begin
         take_q <= grant;
         if (grant) vec_q <= win_idx;
      end
   end

   assign irq_take   = take_q;
   assign irq_vec    = vec_q;
   assign req_state  = req_q;
   assign mask_state = {gie_q, 1'b0, en_q};

   // R7: a take always follows a sampling strobe
   p_take_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_q |-> $past(sample_stb));

   // R10: the grant drops the global enable
   p_take_drops_gie_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take_q |-> !gie_q);

   // R10: the serviced request is no longer pending
   p_take_clears_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take_q |-> !req_q[vec_q]);

   // R12: only an enabled source under an open global enable is granted
   p_take_enabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
      take_q |-> ($past(en_q[win_idx]) && $past(gie_q)));

   // R8: reserved ordering codes never yield a grant
   p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take_q |-> ($past(prio_q[2:0]) != 3'd0 && $past(prio_q[2:0]) != 3'd7));

   // R2: nothing is pending before the first enable operation
   p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |=> $past(req_state) == '0);

endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ext_irq_n = 4'hF;
   logic [5:0] int_set = '0;
   logic       sample_stb = 1'b0, ei_op = 1'b0, di_op = 1'b0, reti_op = 1'b0;
   logic       mask_wr = 1'b0, prio_wr = 1'b0;
   logic [7:0] mask_wdata = '0;
   logic [5:0] prio_wdata = '0;
   logic [5:0] req_clr = '0;
   logic       irq_take;
   logic [2:0] irq_vec;
   logic [5:0] req_state;
   logic [7:0] mask_state;

   int n_chk = 0;
   int n_bad = 0;
   int exp_q[$];
   bit done = 1'b0;

   always #10 clk = ~clk;

   irqc_top uut (
      .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .int_set(int_set),
      .sample_stb(sample_stb), .ei_op(ei_op), .di_op(di_op), .reti_op(reti_op),
      .mask_wr(mask_wr), .mask_wdata(mask_wdata), .prio_wr(prio_wr),
      .prio_wdata(prio_wdata), .req_clr(req_clr), .irq_take(irq_take),
      .irq_vec(irq_vec), .req_state(req_state), .mask_state(mask_state)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: every take must match the head of the scoreboard (R7)
   always @(negedge clk) begin
      if (rst_n && irq_take) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected take", int'(irq_vec), -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(irq_vec) == e, "R7/R8/R9 vector", int'(irq_vec), e);
         end
      end
   end

   // reference winner from the requirement tables (R8, R9)
   function automatic int ref_win(input logic [5:0] pend, input logic [5:0] pr);
      int ord [3];
      int first [3]  = '{5, 2, 1};
      int second [3] = '{3, 0, 4};
      bit sw [3];
      sw[0] = pr[5]; sw[1] = pr[4]; sw[2] = pr[3];
      case (pr[2:0])
         3'd1: ord = '{2, 0, 1};
         3'd2: ord = '{0, 1, 2};
         3'd3: ord = '{0, 2, 1};
         3'd4: ord = '{1, 2, 0};
         3'd5: ord = '{2, 1, 0};
         3'd6: ord = '{1, 0, 2};
         default: return -1;
      endcase
      for (int s = 0; s < 3; s++) begin
         int a, b;
         a = sw[ord[s]] ? second[ord[s]] : first[ord[s]];
         b = sw[ord[s]] ? first[ord[s]]  : second[ord[s]];
         if (pend[a]) return a;
         if (pend[b]) return b;
      end
      return -1;
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   task automatic clear_all();
      req_clr = 6'h3F; step(); req_clr = '0;
   endtask

   // driver: build a state, push the expected winner, fire the strobe
   task automatic try_grant(input logic [5:0] pend, input logic [5:0] en,
                            input logic [5:0] pr, input bit gie, input bit strobe);
      int w;
      clear_all();
      int_set = pend; step(); int_set = '0;
      mask_wdata = {gie, 1'b0, en}; mask_wr = 1'b1; step(); mask_wr = 1'b0;
      prio_wdata = pr; prio_wr = 1'b1; step(); prio_wr = 1'b0;
      w = (gie && strobe) ? ref_win(pend & en, pr) : -1;
      if (w >= 0) exp_q.push_back(w);
      sample_stb = strobe; step(); sample_stb = 1'b0;
      chk(irq_take == (w >= 0), "R7 take pulse", int'(irq_take), int'(w >= 0));
      if (w >= 0) begin
         chk(req_state == (pend & ~(6'(1) << w)), "R10 req after grant",
             int'(req_state), int'(pend & ~(6'(1) << w)));
         chk(mask_state == {1'b0, 1'b0, en}, "R10 gie cleared",
             int'(mask_state), int'({2'b00, en}));
      end else begin
         chk(req_state == pend, "R7 req kept", int'(req_state), int'(pend));
      end
      step();
      chk(irq_take == 1'b0, "R7 single pulse", int'(irq_take), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1
      chk(req_state == 0, "R1 req reset", int'(req_state), 0);
      chk(mask_state == 0, "R1 mask reset", int'(mask_state), 0);
      chk(irq_take == 0, "R1 take reset", int'(irq_take), 0);

      // R2: frozen before first enable
      int_set = 6'h3F; step(); int_set = '0; step();
      chk(req_state == 0, "R2 frozen", int'(req_state), 0);

      // R6: ei sets global enable, arms register
      ei_op = 1'b1; step(); ei_op = 1'b0;
      chk(mask_state == 8'h80, "R6 ei", int'(mask_state), 8'h80);

      // R5: bit 6 reads zero
      mask_wdata = 8'hFF; mask_wr = 1'b1; step(); mask_wr = 1'b0;
      chk(mask_state == 8'hBF, "R5 mask write", int'(mask_state), 8'hBF);

      // R6: di clears only global enable
      di_op = 1'b1; step(); di_op = 1'b0;
      chk(mask_state == 8'h3F, "R6 di", int'(mask_state), 8'h3F);

      // R3: falling edge with two-stage sync
      ext_irq_n[1] = 1'b0; step();
      chk(req_state[1] == 1'b0, "R3 edge+0", int'(req_state), 0);
      step();
      chk(req_state[1] == 1'b0, "R3 edge+1", int'(req_state), 0);
      step();
      chk(req_state == 6'h02, "R3 edge+2", int'(req_state), 6'h02);
      clear_all();
      ext_irq_n[1] = 1'b1; repeat (4) step();
      chk(req_state == 0, "R3 rising ignored", int'(req_state), 0);

      // R4: internal pulse
      int_set = 6'h20; step(); int_set = '0;
      chk(req_state == 6'h20, "R4 internal set", int'(req_state), 6'h20);

      // R11: polled clear of selected bits
      int_set = 6'h11; step(); int_set = '0;
      req_clr = 6'h10; step(); req_clr = '0;
      chk(req_state == 6'h21, "R11 polled clear", int'(req_state), 6'h21);

      // R8: every order code, all pending, no swaps (codes 0, 7 reserved)
      for (int c = 0; c < 8; c++) try_grant(6'h3F, 6'h3F, 6'(c), 1'b1, 1'b1);
      // R9: swap variations
      try_grant(6'h3F, 6'h3F, 6'b111_010, 1'b1, 1'b1);
      try_grant(6'h3F, 6'h3F, 6'b001_101, 1'b1, 1'b1);
      try_grant(6'h3F, 6'h3F, 6'b010_110, 1'b1, 1'b1);
      try_grant(6'h09, 6'h3F, 6'b000_100, 1'b1, 1'b1);
      // R8: fall-through to a later group
      try_grant(6'h01, 6'h3F, 6'd1, 1'b1, 1'b1);
      // R12: masked winner skipped, fully masked gives nothing
      try_grant(6'h3F, 6'h1F, 6'd2, 1'b1, 1'b1);
      try_grant(6'h24, 6'h1B, 6'd2, 1'b1, 1'b1);
      // R7: global enable off, and no strobe
      try_grant(6'h3F, 6'h3F, 6'd2, 1'b0, 1'b1);
      try_grant(6'h3F, 6'h3F, 6'd2, 1'b1, 1'b0);

      // R6: reti restores global enable after a grant
      try_grant(6'h02, 6'h3F, 6'd5, 1'b1, 1'b1);
      reti_op = 1'b1; step(); reti_op = 1'b0;
      chk(mask_state == 8'hBF, "R6 reti", int'(mask_state), 8'hBF);

      repeat (3) step();
      chk(exp_q.size() == 0, "R7 all grants seen", exp_q.size(), 0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule